// File: doc/BRIEF.md
# Memory-Cycle Trap State Holder

This block keeps two sticky state bits for memory traps and turns them into trap requests for the exception controller. The first is the read-trap bit. It records that the last memory read was started with a fault reported by the address-translation logic, so any later use of that read's data must be aborted. The second is the write-trap bit. It records that a started write reported a page fault or a garbage-collection fault.

The read trap does not fire when the read starts. It fires when the data register is sourced, one cycle later, so that the instruction which sourced the data is the one aborted. Sourcing the data does not clear the bit. The trap therefore repeats on every access until a new memory cycle or software clears it. Both bits can be read and written by software, so a handler can save them, use the memory port freely, and put them back before it returns. If the data register is sourced before its contents and the trap bit are valid, a freeze output holds the machine in that cycle.

Top module: `mem_trap_state`

## Requirements
- R1: While `rstN` is low and after reset, `status` is 0 and `rdReq`, `wrReq` are 0.
- R2: A read start (`startRead`=1) with `faultPage` or `faultXport` high sets the read-trap bit (`status[0]`) at the next clock edge.
- R3: Starting a read with no fault, or starting any write, clears the read-trap bit at the next edge. When `startRead` and `startWrite` are both high, the cycle is treated as a read.
- R4: `rdReq` is high in the cycle after a cycle in which `mdSource`=1, `mdValid`=1 and the read-trap bit was 1. It is low in every other cycle.
- R5: Sourcing the data register leaves the read-trap bit unchanged, so repeated sourcing raises `rdReq` again each time.
- R6: `freeze` equals `mdSource && !mdValid` in the same cycle. A frozen cycle raises no `rdReq` in the next cycle.
- R7: A write start with `faultPage` or `faultXport` high sets the write-trap bit (`status[1]`) at the next edge. `wrReq` is high in every cycle the bit is set.
- R8: The write-trap bit stays set until software clears it or a later memory cycle starts. A write start without a fault clears it, and so does any read start.
- R9: A software write (`swWe`=1) loads `swData[0]` into the read-trap bit and `swData[1]` into the write-trap bit at the next edge. It takes priority over any memory start in the same cycle.
- R10: `status[2]` is a read-only copy of the current read trap request (`rdReq`). Software writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startRead | input | 1 | A memory read (normal or early) starts this cycle |
| startWrite | input | 1 | A memory write starts this cycle |
| faultPage | input | 1 | Translation reports a page fault for the starting cycle |
| faultXport | input | 1 | Transport (read) or GC (write) fault for the starting cycle |
| mdSource | input | 1 | The current instruction sources the memory data register |
| mdValid | input | 1 | Data register and read-trap bit are valid |
| swWe | input | 1 | Software write of the trap bits |
| swData | input | 2 | Bit 0 is the new read-trap value, bit 1 is the new write-trap value |
| rdReq | output | 1 | Read trap request |
| wrReq | output | 1 | Write trap request |
| status | output | 3 | {rdReq, write-trap bit, read-trap bit} |
| freeze | output | 1 | Hold the machine in the sourcing cycle |

## Verification
A wrong read-trap bit shows at `status[0]` one cycle after the memory start or software write that set it. It shows at `rdReq` one cycle after the next valid sourcing of the data register. A wrong write-trap bit shows on `status[1]` and `wrReq` in the cycle right after the edge that loaded it. A mistimed request shows as `rdReq` one cycle early or late relative to the sourcing cycle. The bench compares every port in every cycle, so a divergence is caught in the cycle it first appears.

// File: rtl/mem_trap_pkg.sv
package mem_trap_pkg;
  localparam int STAT_W   = 3;
  localparam int RD_POS   = 0;
  localparam int WR_POS   = 1;
  localparam int REQ_POS  = 2;
  localparam int SW_W     = 2;

  typedef struct packed {
    logic loadSw;     // software load of both bits
    logic rdLoad;     // read-trap bit takes rdVal
    logic rdVal;
    logic wrLoad;     // write-trap bit takes wrVal
    logic wrVal;
    logic sampleMd;   // valid sourcing of data register this cycle
  } trapStrobes_t;
endpackage

// File: rtl/mem_trap_ctrl.sv
module mem_trap_ctrl
  import mem_trap_pkg::*;
(
  input  logic         startRead,
  input  logic         startWrite,
  input  logic         faultPage,
  input  logic         faultXport,
  input  logic         mdSource,
  input  logic         mdValid,
  input  logic         swWe,
  output trapStrobes_t strobes,
  output logic         freeze
);
  logic anyFault;
  logic isRead;
  logic isWrite;

  always_comb begin
    anyFault = faultPage | faultXport;
    isRead   = startRead;
    isWrite  = startWrite & ~startRead;

    strobes          = '0;
    strobes.loadSw   = swWe;
    strobes.sampleMd = mdSource & mdValid;
    if (!swWe) begin
      if (isRead) begin
        strobes.rdLoad = 1'b1;
        strobes.rdVal  = anyFault;
        strobes.wrLoad = 1'b1;
        strobes.wrVal  = 1'b0;
      end else if (isWrite) begin
        strobes.rdLoad = 1'b1;
        strobes.rdVal  = 1'b0;
        strobes.wrLoad = 1'b1;
        strobes.wrVal  = anyFault;
      end
    end
    freeze = mdSource & ~mdValid;
  end
endmodule

// File: rtl/mem_trap_dp.sv
module mem_trap_dp
  import mem_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobes_t      strobes,
  input  logic [SW_W-1:0]   swData,
  output logic              rdTrap,
  output logic              wrTrap,
  output logic              rdPend
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdTrap <= 1'b0;
      wrTrap <= 1'b0;
      rdPend <= 1'b0;
    end else begin
      rdPend <= strobes.sampleMd & rdTrap;
      if (strobes.loadSw) begin
        rdTrap <= swData[RD_POS];
        wrTrap <= swData[WR_POS];
      end else begin
        if (strobes.rdLoad) rdTrap <= strobes.rdVal;
        if (strobes.wrLoad) wrTrap <= strobes.wrVal;
      end
    end
  end
endmodule

// File: rtl/mem_trap_state.sv
module mem_trap_state
  import mem_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRead,
  input  logic              startWrite,
  input  logic              faultPage,
  input  logic              faultXport,
  input  logic              mdSource,
  input  logic              mdValid,
  input  logic              swWe,
  input  logic [SW_W-1:0]   swData,
  output logic              rdReq,
  output logic              wrReq,
  output logic [STAT_W-1:0] status,
  output logic              freeze
);
  trapStrobes_t strobes;
  logic rdTrap;
  logic wrTrap;
  logic rdPend;

  mem_trap_ctrl u_ctrl (
    .startRead (startRead),
    .startWrite(startWrite),
    .faultPage (faultPage),
    .faultXport(faultXport),
    .mdSource  (mdSource),
    .mdValid   (mdValid),
    .swWe      (swWe),
    .strobes   (strobes),
    .freeze    (freeze)
  );

  mem_trap_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .swData (swData),
    .rdTrap (rdTrap),
    .wrTrap (wrTrap),
    .rdPend (rdPend)
  );

  assign rdReq = rdPend;
  assign wrReq = wrTrap;

  always_comb begin
    status          = '0;
    status[RD_POS]  = rdTrap;
    status[WR_POS]  = wrTrap;
    status[REQ_POS] = rdPend;
  end
endmodule

// File: rtl/mem_trap_state_chk.sv
module mem_trap_state_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startRead,
  input logic       startWrite,
  input logic       faultPage,
  input logic       faultXport,
  input logic       mdSource,
  input logic       mdValid,
  input logic       swWe,
  input logic [1:0] swData,
  input logic       rdReq,
  input logic       wrReq,
  input logic [2:0] status,
  input logic       freeze
);
  // R4
  req_after_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdSource && mdValid && status[0]) |=> rdReq);

  // R6
  freeze_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdSource && !mdValid) |=> !rdReq);

  // R5
  source_keeps_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdSource && !startRead && !startWrite && !swWe) |=> $stable(status[0]));

  // R2
  read_fault_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startRead && (faultPage || faultXport) && !swWe) |=> status[0]);

  // R9
  sw_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    swWe |=> (status[1:0] == $past(swData)));

  // R7
  write_fault_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startWrite && !startRead && (faultPage || faultXport) && !swWe) |=> wrReq);
endmodule

bind mem_trap_state mem_trap_state_chk u_chk (.*);

// File: tb/mem_trap_state_test.sv
module mem_trap_state_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startRead = 1'b0, startWrite = 1'b0;
  logic       faultPage = 1'b0, faultXport = 1'b0;
  logic       mdSource = 1'b0, mdValid = 1'b1;
  logic       swWe = 1'b0;
  logic [1:0] swData = 2'b00;
  logic       rdReq, wrReq, freeze;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;
  bit mRd = 0, mWr = 0, mReq = 0;

  always #2 clk = ~clk;

  mem_trap_state uut (.*);

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit nextRd(bit cur);
    if (swWe) return swData[0];
    if (startRead) return faultPage | faultXport;
    if (startWrite) return 1'b0;
    return cur;
  endfunction

  function automatic bit nextWr(bit cur);
    if (swWe) return swData[1];
    if (startRead) return 1'b0;
    if (startWrite) return faultPage | faultXport;
    return cur;
  endfunction

  // Drive at negedge; check freeze; advance model and check outputs after posedge.
  task automatic step(input bit sr, input bit sw, input bit fp, input bit fx,
                      input bit ms, input bit mv, input bit we, input bit [1:0] wd);
    bit nR, nW, nQ;
    @(negedge clk);
    startRead = sr; startWrite = sw; faultPage = fp; faultXport = fx;
    mdSource = ms; mdValid = mv; swWe = we; swData = wd;
    #0.5;
    check("R6 freeze", {3'b0, freeze}, {3'b0, ms & ~mv});
    nQ = ms & mv & mRd;
    nR = nextRd(mRd);
    nW = nextWr(mWr);
    @(posedge clk);
    #1;
    mRd = nR; mWr = nW; mReq = nQ;
    check("R2 R3 R5 R9 rdTrap", {3'b0, status[0]}, {3'b0, mRd});
    check("R7 R8 R9 wrTrap", {3'b0, status[1]}, {3'b0, mWr});
    check("R7 wrReq", {3'b0, wrReq}, {3'b0, mWr});
    check("R4 R6 rdReq", {3'b0, rdReq}, {3'b0, mReq});
    check("R10 status req bit", {3'b0, status[2]}, {3'b0, mReq});
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset status", {1'b0, status}, 4'h0);
    check("R1 reset reqs", {2'b0, rdReq, wrReq}, 4'h0);
    @(negedge clk) rstN = 1'b1;

    // R2 read with page fault sets; R5 repeated sourcing repeats request
    step(1,0,1,0, 0,1, 0,2'b00);
    check("R2 set by read fault", {3'b0, status[0]}, 4'h1);
    step(0,0,0,0, 1,1, 0,2'b00);
    check("R4 req follows source", {3'b0, rdReq}, 4'h1);
    step(0,0,0,0, 1,1, 0,2'b00);
    check("R5 req repeats", {3'b0, rdReq}, 4'h1);
    step(0,0,0,0, 0,1, 0,2'b00);
    check("R4 no req without source", {3'b0, rdReq}, 4'h0);
    check("R5 bit kept", {3'b0, status[0]}, 4'h1);
    // R6 frozen sourcing yields no request
    step(0,0,0,0, 1,0, 0,2'b00);
    check("R6 no req after freeze", {3'b0, rdReq}, 4'h0);
    // R3 write start clears read bit even with fault; R7 sets write bit
    step(0,1,0,1, 0,1, 0,2'b00);
    check("R3 write clears rd", {3'b0, status[0]}, 4'h0);
    check("R7 write fault sets", {3'b0, wrReq}, 4'h1);
    step(0,0,0,0, 0,1, 0,2'b00);
    check("R8 write bit holds", {3'b0, status[1]}, 4'h1);
    // R8 read start clears write bit; R3 clean read clears rd
    step(1,0,0,0, 0,1, 0,2'b00);
    check("R8 read clears wr", {3'b0, status[1]}, 4'h0);
    // R9 software priority over a faulting read start
    step(1,0,1,1, 0,1, 1,2'b10);
    check("R9 sw wins", {2'b0, status[1:0]}, 4'h2);
    // R3 simultaneous starts treated as read
    step(1,1,1,0, 0,1, 0,2'b00);
    check("R3 both starts as read", {2'b0, status[1:0]}, 4'h1);
    // R10 software write does not touch request bit
    step(0,0,0,0, 1,1, 1,2'b00);
    check("R10 req despite sw", {1'b0, status}, 4'h4);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 100) < 15, ($urandom % 100) < 15,
           ($urandom % 100) < 30, ($urandom % 100) < 20,
           ($urandom % 100) < 35, ($urandom % 100) < 80,
           ($urandom % 100) < 6, 2'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule